// File: doc/BRIEF.md
# PHY Management Register Model

This block receives management frames from a host and serves them from a small register model of a single Ethernet PHY. The host writes one 32-bit word into the frame register, and that write starts exactly one PHY access. Bit 29 of the word selects a read or a write. A read returns the 16-bit register value in the low half of the frame register. Both kinds of access raise a one-cycle done pulse, which the surrounding controller can latch as its management-done interrupt event.

Behind the frame register sits a model of the PHY's control, status, advertisement, interrupt-source and interrupt-mask registers. Each has a fixed reset value and a fixed write mask. Autonegotiation completes in the same cycle it is enabled. A level input reports the link state. Each change of that level updates the link and autonegotiation-complete status bits and latches interrupt-source flags. The source flags clear when software reads them.

Top module: `mdio_phy_model`

## Requirements
- R1: After reset, control reads 0x3000, status 0x7809, advertisement 0x01E1, and interrupt source and mask read 0. The frame register is 0, the done output is low, and the sampled link level is down.
- R2: In the frame word, bit 29 = 1 requests a read and bit 29 = 0 requests a write. Bits 27:18 hold a 10-bit address whose values 0..31 select a PHY register and whose values 32 and above are out of range. Bits 15:0 hold the write data.
- R3: On a read, the frame register takes bits 31:16 from the written word and bits 15:0 from the addressed register. On a write, the frame register holds the written word unchanged.
- R4: The done output is high for exactly the one cycle after each frame write and low otherwise.
- R5: A write to register 0 stores the data ANDed with 0x7980. If data bit 12 is set, status bit 0x0020 is set at the same clock edge.
- R6: A write to register 4 stores (data AND 0x2D7F) OR 0x0080.
- R7: A write to register 30 keeps only data bits 7:0.
- R8: Register 0 reads control, 1 reads status, 4 reads advertisement, 29 reads interrupt source and 30 reads mask. Registers 5 and 6, every other register number and every out-of-range address read 0.
- R9: A read of register 29 returns the current interrupt source and clears it at that edge.
- R10: A change of the link input from up to down clears status bits 0x0024 and sets source bit 4. A change from down to up sets status bits 0x0024 and sets source bits 7 and 6. An unchanged level has no effect.
- R11: A write to register 1, 5, 6, 29 or any other register number apart from 0, 4 and 30, or to an out-of-range address, leaves every register unchanged.
- R12: When a management access and a link change share a clock edge, the link update is applied after the access. A link-down clears the status bit that a control write has just set. Source flags set by the link survive a read-clear of register 29 at the same edge, and that read returns the value the register held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_wr | input | 1 | Write strobe for the management frame register |
| frame_wdata | input | 32 | Management frame word |
| link_up | input | 1 | Current link level, 1 = up |
| frame_q | output | 32 | Frame register contents, including read data |
| mgmt_done | output | 1 | One-cycle pulse marking a finished access |

## Verification
Two updates can meet at one edge: a management access and a link-level change. The bench flips the link input in the same cycle as a control write with bit 12 set, and again in the same cycle as a read of the interrupt source. It also changes the link on random cycles during a long stream of random accesses. It judges the outcome by reading status and interrupt source back through later frames and comparing against a model that applies the access first and the link update second.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;
  localparam int FRAME_W  = 32;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 10;
  localparam int REGN_W   = 5;
  localparam int OP_BIT   = 29;
  localparam int ADDR_LSB = 18;

  localparam logic [REGN_W-1:0] RN_CTRL = 5'd0;
  localparam logic [REGN_W-1:0] RN_STAT = 5'd1;
  localparam logic [REGN_W-1:0] RN_ADV  = 5'd4;
  localparam logic [REGN_W-1:0] RN_ISRC = 5'd29;
  localparam logic [REGN_W-1:0] RN_IMSK = 5'd30;

  localparam logic [DATA_W-1:0] CTRL_RST = 16'h3000;
  localparam logic [DATA_W-1:0] STAT_RST = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_RST  = 16'h01E1;

  localparam logic [DATA_W-1:0] STAT_LINK_BITS = 16'h0024;
  localparam logic [DATA_W-1:0] STAT_ANEG_DONE = 16'h0020;
  localparam logic [DATA_W-1:0] ISRC_DOWN      = 16'h0010;
  localparam logic [DATA_W-1:0] ISRC_UP        = 16'h00C0;
  localparam int                CTRL_ANEG_BIT  = 12;

  function automatic logic [DATA_W-1:0] ctrl_wr_fn(input logic [DATA_W-1:0] d);
    return d & 16'h7980;
  endfunction

  function automatic logic [DATA_W-1:0] adv_wr_fn(input logic [DATA_W-1:0] d);
    return (d & 16'h2D7F) | 16'h0080;
  endfunction

  function automatic logic [DATA_W-1:0] imsk_wr_fn(input logic [DATA_W-1:0] d);
    return d & 16'h00FF;
  endfunction

  function automatic logic [DATA_W-1:0] link_stat_fn(input logic [DATA_W-1:0] s,
                                                     input logic rise, input logic fall);
    logic [DATA_W-1:0] r;
    r = s;
    if (fall) r = r & ~STAT_LINK_BITS;
    if (rise) r = r | STAT_LINK_BITS;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] link_isrc_fn(input logic [DATA_W-1:0] s,
                                                     input logic rise, input logic fall);
    logic [DATA_W-1:0] r;
    r = s;
    if (fall) r = r | ISRC_DOWN;
    if (rise) r = r | ISRC_UP;
    return r;
  endfunction
endpackage

// File: rtl/mdio_frame_decode.sv
module mdio_frame_decode #(
  parameter int ADDR_W = 10,
  parameter int REGN_W = 5
) (
  input  logic              frame_wr,
  input  logic              op_bit,
  input  logic [ADDR_W-1:0] addr_field,
  output logic              acc_rd,
  output logic              acc_wr,
  output logic              addr_ok,
  output logic [REGN_W-1:0] reg_sel
);
  localparam int HI_W = ADDR_W - REGN_W;

  always_comb begin
    acc_rd  = frame_wr & op_bit;
    acc_wr  = frame_wr & ~op_bit;
    addr_ok = (addr_field[ADDR_W-1:REGN_W] == {HI_W{1'b0}});
    reg_sel = addr_field[REGN_W-1:0];
  end
endmodule

// File: rtl/mdio_link_track.sv
module mdio_link_track (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  output logic link_rise,
  output logic link_fall
);
  logic link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  always_comb begin
    link_rise = link_up & ~link_q;
    link_fall = ~link_up & link_q;
  end
endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
  import mdio_phy_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REGN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              addr_ok,
  input  logic [REGN_W-1:0] reg_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              link_rise,
  input  logic              link_fall,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] isrc_q,
  output logic              isrc_rd_hit
);
  logic [DATA_W-1:0] ctrl_q, adv_q, imsk_q;
  logic [DATA_W-1:0] stat_mid, isrc_mid;
  logic              wr_hit;

  assign wr_hit      = acc_wr & addr_ok;
  assign isrc_rd_hit = acc_rd & addr_ok & (reg_sel == RN_ISRC);

  always_comb begin
    rd_data = '0;
    if (addr_ok) begin
      case (reg_sel)
        RN_CTRL: rd_data = ctrl_q;
        RN_STAT: rd_data = status_q;
        RN_ADV:  rd_data = adv_q;
        RN_ISRC: rd_data = isrc_q;
        RN_IMSK: rd_data = imsk_q;
        default: rd_data = '0;
      endcase
    end
  end

  // access effect first, link effect on top of it
  always_comb begin
    stat_mid = status_q;
    if (wr_hit && reg_sel == RN_CTRL && wdata[CTRL_ANEG_BIT])
      stat_mid = status_q | STAT_ANEG_DONE;
    isrc_mid = isrc_rd_hit ? '0 : isrc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      status_q <= STAT_RST;
      adv_q    <= ADV_RST;
      isrc_q   <= '0;
      imsk_q   <= '0;
    end else begin
      status_q <= link_stat_fn(stat_mid, link_rise, link_fall);
      isrc_q   <= link_isrc_fn(isrc_mid, link_rise, link_fall);
      if (wr_hit) begin
        case (reg_sel)
          RN_CTRL: ctrl_q <= ctrl_wr_fn(wdata);
          RN_ADV:  adv_q  <= adv_wr_fn(wdata);
          RN_IMSK: imsk_q <= imsk_wr_fn(wdata);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_phy_model.sv
module mdio_phy_model
  import mdio_phy_pkg::*;
#(
  parameter int P_FRAME_W = FRAME_W,
  parameter int P_DATA_W  = DATA_W,
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_REGN_W  = REGN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_wr,
  input  logic [P_FRAME_W-1:0] frame_wdata,
  input  logic                 link_up,
  output logic [P_FRAME_W-1:0] frame_q,
  output logic                 mgmt_done
);
  localparam int UP_W = P_FRAME_W - P_DATA_W;

  logic                acc_rd, acc_wr, addr_ok;
  logic [P_REGN_W-1:0] reg_sel;
  logic                link_rise, link_fall;
  logic [P_DATA_W-1:0] rd_data, status_q, isrc_q;
  logic                isrc_rd_hit;

  mdio_frame_decode #(.ADDR_W(P_ADDR_W), .REGN_W(P_REGN_W)) dec_i (
    .frame_wr   (frame_wr),
    .op_bit     (frame_wdata[OP_BIT]),
    .addr_field (frame_wdata[ADDR_LSB +: P_ADDR_W]),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .addr_ok    (addr_ok),
    .reg_sel    (reg_sel)
  );

  mdio_link_track lnk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .link_rise (link_rise),
    .link_fall (link_fall)
  );

  mdio_phy_regs #(.DATA_W(P_DATA_W), .REGN_W(P_REGN_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .addr_ok     (addr_ok),
    .reg_sel     (reg_sel),
    .wdata       (frame_wdata[P_DATA_W-1:0]),
    .link_rise   (link_rise),
    .link_fall   (link_fall),
    .rd_data     (rd_data),
    .status_q    (status_q),
    .isrc_q      (isrc_q),
    .isrc_rd_hit (isrc_rd_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q   <= '0;
      mgmt_done <= 1'b0;
    end else begin
      mgmt_done <= frame_wr;
      if (frame_wr)
        frame_q <= acc_rd ? {frame_wdata[P_FRAME_W-1 -: UP_W], rd_data} : frame_wdata;
    end
  end
endmodule

// File: rtl/mdio_phy_model_chk.sv
module mdio_phy_model_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_wr,
  input logic [31:0] frame_wdata,
  input logic [31:0] frame_q,
  input logic        mgmt_done,
  input logic        link_rise,
  input logic        link_fall,
  input logic [15:0] status_q,
  input logic [15:0] isrc_q,
  input logic        isrc_rd_hit
);
  // R4
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr |=> mgmt_done);
  // R4
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wr |=> !mgmt_done);
  // R3
  upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wr |=> frame_q[31:16] == $past(frame_wdata[31:16]));
  // R3
  write_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr && !frame_wdata[29]) |=> frame_q == $past(frame_wdata));
  // R9
  isrc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isrc_rd_hit && !link_rise && !link_fall) |=> isrc_q == 16'h0000);
  // R10
  link_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fall |=> ((status_q & 16'h0024) == 16'h0000) && ((isrc_q & 16'h0010) != 16'h0000));
  // R10
  link_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_rise |=> ((status_q & 16'h0024) == 16'h0024) && ((isrc_q & 16'h00C0) == 16'h00C0));
endmodule

bind mdio_phy_model mdio_phy_model_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_wr    (frame_wr),
  .frame_wdata (frame_wdata),
  .frame_q     (frame_q),
  .mgmt_done   (mgmt_done),
  .link_rise   (link_rise),
  .link_fall   (link_fall),
  .status_q    (status_q),
  .isrc_q      (isrc_q),
  .isrc_rd_hit (isrc_rd_hit)
);

// File: tb/mdio_phy_model_tb_top.sv
`timescale 1ns/1ps
module mdio_phy_model_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_wr = 1'b0;
  logic [31:0] frame_wdata = '0;
  logic        link_up = 1'b0;
  logic [31:0] frame_q;
  logic        mgmt_done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] m_ctrl, m_stat, m_adv, m_isrc, m_imsk;
  bit          m_link;

  always #2.5 clk = ~clk;

  mdio_phy_model dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_wr    (frame_wr),
    .frame_wdata (frame_wdata),
    .link_up     (link_up),
    .frame_q     (frame_q),
    .mgmt_done   (mgmt_done)
  );

  function automatic logic [15:0] exp_read(input logic [9:0] a);
    if (a >= 10'd32) return 16'h0000;
    case (a[4:0])
      5'd0:  return m_ctrl;
      5'd1:  return m_stat;
      5'd4:  return m_adv;
      5'd29: return m_isrc;
      5'd30: return m_imsk;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] exp_frame = '0;

  // called at a negedge; returns at the following negedge after checking
  task automatic step(input bit do_op, input bit rd, input logic [9:0] a,
                      input logic [15:0] d, input bit lnk, input string tag);
    logic [31:0] word;
    logic [15:0] rv;
    bit rise, fall;
    word = {2'b10, rd, 1'b0, a, 2'b01, d};
    rv = exp_read(a);
    frame_wr = do_op;
    frame_wdata = word;
    link_up = lnk;
    rise = lnk & ~m_link;
    fall = ~lnk & m_link;
    if (do_op) exp_frame = rd ? {word[31:16], rv} : word;
    if (do_op && !rd && a < 10'd32) begin
      case (a[4:0])
        5'd0: begin
          m_ctrl = d & 16'h7980;
          if (d[12]) m_stat = m_stat | 16'h0020;
        end
        5'd4:  m_adv  = (d & 16'h2D7F) | 16'h0080;
        5'd30: m_imsk = {8'h00, d[7:0]};
        default: ;
      endcase
    end
    if (do_op && rd && a == 10'd29) m_isrc = 16'h0000;
    if (fall) begin m_stat = m_stat & ~16'h0024; m_isrc = m_isrc | 16'h0010; end
    if (rise) begin m_stat = m_stat | 16'h0024;  m_isrc = m_isrc | 16'h00C0; end
    m_link = lnk;
    @(posedge clk);
    @(negedge clk);
    frame_wr = 1'b0;
    chk({tag, " frame"}, frame_q, exp_frame);
    chk("R4 done pulse", {31'd0, mgmt_done}, {31'd0, do_op});
  endtask

  task automatic rd_reg(input logic [9:0] a, input string tag);
    step(1'b1, 1'b1, a, 16'hA5A5, m_link, tag);
  endtask

  task automatic wr_reg(input logic [9:0] a, input logic [15:0] d, input string tag);
    step(1'b1, 1'b0, a, d, m_link, tag);
  endtask

  initial begin
    m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
    m_isrc = 16'h0000; m_imsk = 16'h0000; m_link = 1'b0;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 frame reset", frame_q, 32'h0);
    chk("R1 done reset", {31'd0, mgmt_done}, 32'h0);
    rd_reg(10'd0,  "R1 ctrl reset");
    rd_reg(10'd1,  "R1 status reset");
    rd_reg(10'd4,  "R1 adv reset");
    rd_reg(10'd29, "R1 isrc reset");
    rd_reg(10'd30, "R1 imask reset");
    rd_reg(10'd5,  "R8 reg5 zero");
    rd_reg(10'd6,  "R8 reg6 zero");
    rd_reg(10'd2,  "R8 unimpl zero");
    rd_reg(10'd33, "R2 out of range read");
    wr_reg(10'd0, 16'hFFFF, "R5 ctrl write");
    rd_reg(10'd0, "R5 ctrl mask");
    rd_reg(10'd1, "R5 aneg status");
    wr_reg(10'd4, 16'hFFFF, "R6 adv write");
    rd_reg(10'd4, "R6 adv mask");
    wr_reg(10'd4, 16'h0000, "R6 adv zero");
    rd_reg(10'd4, "R6 adv forced bit");
    wr_reg(10'd30, 16'hFFFF, "R7 imask write");
    rd_reg(10'd30, "R7 imask mask");
    wr_reg(10'd1,  16'h0000, "R11 status write");
    wr_reg(10'd29, 16'hFFFF, "R11 isrc write");
    wr_reg(10'd5,  16'hFFFF, "R11 reg5 write");
    wr_reg({5'd1, 5'd0}, 16'h0000, "R11 out of range ctrl");
    rd_reg(10'd0,  "R11 ctrl kept");
    rd_reg(10'd1,  "R11 status kept");
    rd_reg(10'd29, "R11 isrc kept");
    rd_reg(10'd5,  "R11 reg5 still zero");
    step(1'b0, 1'b0, 10'd0, 16'h0, 1'b1, "R10 link up idle");
    rd_reg(10'd1,  "R10 status link up");
    rd_reg(10'd29, "R9 isrc read");
    rd_reg(10'd29, "R9 isrc cleared");
    step(1'b0, 1'b0, 10'd0, 16'h0, 1'b1, "R10 level unchanged");
    rd_reg(10'd29, "R10 no event on steady");
    wr_reg(10'd0, 16'h0000, "R5 ctrl clear");
    step(1'b1, 1'b0, 10'd0, 16'h1000, 1'b0, "R12 ctrl write with link down");
    rd_reg(10'd1,  "R12 status after both");
    step(1'b1, 1'b1, 10'd29, 16'h0, 1'b1, "R12 isrc read with link up");
    rd_reg(10'd29, "R12 isrc after both");
    rd_reg(10'd1,  "R10 status relinked");
    for (int i = 0; i < 400; i++) begin
      logic [9:0] a;
      bit lnk;
      case ($urandom % 10)
        0: a = 10'd0;
        1: a = 10'd1;
        2: a = 10'd4;
        3: a = 10'd5;
        4: a = 10'd29;
        5: a = 10'd30;
        6: a = 10'd31;
        7: a = 10'($urandom);
        default: a = 10'($urandom % 32);
      endcase
      lnk = (($urandom % 4) == 0) ? ~m_link : m_link;
      step((($urandom % 8) != 0), 1'($urandom), a, 16'($urandom), lnk, "R8 R12 random");
    end
    rd_reg(10'd0, "R3 final ctrl");
    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule